// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit up-counter with one control byte and two double-buffered 16-bit compare registers, A and B. The counter runs in one of four modes:

- An interval timer. The same mode also serves as a timer started by an external trigger and as an event counter.
- Gated window counting.
- Pulse-width measurement with capture.
- Programmable pulse generation on a timer flip-flop output.

Software reaches the block through a byte-wide write/read port. The block picks its count strobe from three clock-enable inputs that are already divided, or it counts edges of the synchronized external pin.

A 2-bit start field controls starting and stopping for every mode. It can stop the counter and clear it, start it on a software command, or respond to pin edges or pin levels. Matches against register A clear the counter and raise a one-cycle interrupt. In pulse-generation mode, matches against B and against A toggle the timer flip-flop. The result of a pulse measurement, or the live count when auto-capture is enabled, appears on a 16-bit capture output.

Top module: `multimode_timer`

## Requirements
- R1: After reset, registers A and B read 0xFFFF, and tff_o, irq_o and capture_o are 0. The control byte is 0, which selects timer mode, stopped.
- R2: Register addresses are 1 (A low byte), 2 (A high byte), 3 (B low byte), 4 (B high byte), 5 and 6 (capture low and high, read only), and 0 (control). A high-byte write moves the buffered 16-bit value into the active register on the first source tick after that write. A write to only the low byte never changes the active register.
- R3: Writes to register B have no effect unless the mode field is 11 (pulse generation).
- R4: The control byte layout is: bits 1:0 mode, bits 3:2 start, bits 5:4 clock select, bit 6 mode option, bit 7 flip-flop preset. Start value 00 stops the counter and clears it. While stopped, tff_o takes the preset bit one cycle later.
- R5: Timer mode (mode 00, start 01): a sw_start_i pulse starts counting. On the tick where count+1 equals A, the counter clears and irq_o pulses for one cycle, so an interrupt arrives every A ticks.
- R6: Auto-capture (mode 00, start 01, option 1): capture_o follows the live count on every cycle.
- R7: External trigger (mode 00, start 10 for rising or 11 for falling, clock select other than 11): the selected pin edge starts the counter. With option 1, the next such edge stops the counter and clears it. With option 0, later edges are ignored.
- R8: Event counting (mode 00, clock select 11): each synchronized pin edge of the polarity chosen by start (10 rising, 11 falling) is one count tick.
- R9: Window mode (mode 01) counts ticks only while the pin is high (start 10) or low (start 11).
- R10: Pulse width, single edge (mode 10, option 1): the active edge clears the counter and starts it. The opposite edge captures the width in ticks, including the tick of that cycle, pulses irq_o, then stops the counter and clears it.
- R11: Pulse width, double edge (mode 10, option 0): the opposite edge captures the width and counting continues. The next active edge captures the full period, restarts from 0, and pulses irq_o. Each capture raises irq_o.
- R12: Pulse generation (mode 11, option 0): tff_o toggles on a match with B and again on a match with A, and the counter clears at A. The output repeats every A ticks.
- R13: Pulse generation, one-shot (option 1): the counter halts after the first match with A. tff_o then holds and no further interrupt occurs.
- R14: Clock select values 00, 01 and 10 choose ce_div_i[0], ce_div_i[1] and ce_div_i[2] as the count tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| ce_div_i | input | 3 | Divided clock-enable strobes |
| pin_i | input | 1 | External pin, asynchronous |
| sw_start_i | input | 1 | Software start command |
| tff_o | output | 1 | Timer flip-flop output |
| irq_o | output | 1 | One-cycle interrupt pulse |
| capture_o | output | 16 | Captured or live count |

## Verification
The bench uses the default parameters: a 16-bit counter, three divided strobes and a two-stage pin synchronizer. The bench drives the strobes at ratios of 1, 1/2 and 1/4, so the effect of clock select shows as interrupt periods of 10 and 20 cycles for A = 5. The fixed three-edge pin latency means every pulse-width capture can be predicted exactly, and the bench checks single-edge and double-edge captures to the tick. Small values in A and B make complete pulse-generation periods and the one-shot halt visible within a few dozen cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_TMR = 2'b00,
    MODE_WIN = 2'b01,
    MODE_PW  = 2'b10,
    MODE_PPG = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_STOP = 2'b00,
    ST_CMD  = 2'b01,
    ST_RISE = 2'b10,
    ST_FALL = 2'b11
  } start_e;

  typedef struct packed {
    logic       tff_init;
    logic       opt;
    logic [1:0] clk_sel;
    start_e     start;
    mode_e      mode;
  } ctrl_t;

  localparam logic [1:0] SEL_PIN = 2'b11;

  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_A_LO   = 3'd1;
  localparam logic [2:0] ADR_A_HI   = 3'd2;
  localparam logic [2:0] ADR_B_LO   = 3'd3;
  localparam logic [2:0] ADR_B_HI   = 3'd4;
  localparam logic [2:0] ADR_CAP_LO = 3'd5;
  localparam logic [2:0] ADR_CAP_HI = 3'd6;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq     <= '0;
      prev_q <= 1'b0;
    end else begin
      sq     <= {sq[STAGES-2:0], pin_i};
      prev_q <= sq[STAGES-1];
    end
  end

  assign level_o = sq[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/tmr_dbuf.sv
module tmr_dbuf
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [W-1:0]      val_o
);
  logic [BYTE_W-1:0] lo_q;
  logic [W-1:0]      stage_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '1;
      stage_q <= '1;
      pend_q  <= 1'b0;
      val_o   <= '1;
    end else begin
      if (we_lo_i) lo_q <= wdata_i;
      if (load_i && pend_q) begin
        val_o  <= stage_q;
        pend_q <= 1'b0;
      end
      if (we_hi_i) begin
        stage_q <= {wdata_i[W-BYTE_W-1:0], lo_q};
        pend_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             tick_i,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sw_start_i,
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             tff_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_n, cap_n, inc, sum;
  logic             run_q, run_n, tff_n, irq_n;
  logic             act, inact, lvl_ok, hit_a, hit_b, step_en, ext_trig, ppg;

  always_comb begin
    act      = (ctrl_i.start == ST_FALL) ? fall_i : rise_i;
    inact    = (ctrl_i.start == ST_FALL) ? rise_i : fall_i;
    lvl_ok   = (ctrl_i.start == ST_FALL) ? ~lvl_i : lvl_i;
    inc      = cnt_o + 1'b1;
    sum      = cnt_o + CNT_W'(tick_i);
    hit_a    = (inc == a_i);
    hit_b    = (inc == b_i);
    ppg      = (ctrl_i.mode == MODE_PPG);
    ext_trig = (ctrl_i.clk_sel != SEL_PIN);
    step_en  = run_q && (ctrl_i.mode != MODE_PW) &&
               ((ctrl_i.mode != MODE_WIN) || lvl_ok);

    run_n = run_q;
    cnt_n = cnt_o;
    cap_n = cap_o;
    tff_n = tff_o;
    irq_n = 1'b0;

    if (step_en && tick_i) begin
      if (hit_a) begin
        cnt_n = '0;
        irq_n = 1'b1;
        if (ppg && ctrl_i.opt) run_n = 1'b0;
      end else begin
        cnt_n = inc;
      end
      if (ppg) tff_n = tff_o ^ hit_a ^ hit_b;
    end

    unique case (ctrl_i.mode)
      MODE_TMR: begin
        if (ctrl_i.start == ST_CMD) begin
          if (sw_start_i) run_n = 1'b1;
        end else if (!ext_trig) begin
          run_n = 1'b1;
        end else if (act) begin
          if (run_q && ctrl_i.opt) begin
            run_n = 1'b0;
            cnt_n = '0;
          end else begin
            run_n = 1'b1;
          end
        end
      end
      MODE_WIN: run_n = 1'b1;
      MODE_PW: begin
        if (run_q && tick_i) cnt_n = inc;
        if (act) begin
          if (run_q && !ctrl_i.opt) begin
            cap_n = sum;
            irq_n = 1'b1;
          end
          cnt_n = '0;
          run_n = 1'b1;
        end else if (inact && run_q) begin
          cap_n = sum;
          irq_n = 1'b1;
          if (ctrl_i.opt) begin
            run_n = 1'b0;
            cnt_n = '0;
          end
        end
      end
      MODE_PPG: begin
        if (ctrl_i.start == ST_CMD) begin
          if (sw_start_i) run_n = 1'b1;
        end else if (act) begin
          run_n = 1'b1;
        end
      end
    endcase

    if (ctrl_i.mode == MODE_TMR && ctrl_i.start == ST_CMD && ctrl_i.opt) cap_n = cnt_n;

    if (ctrl_i.start == ST_STOP) begin
      run_n = 1'b0;
      cnt_n = '0;
      irq_n = 1'b0;
      tff_n = ctrl_i.tff_init;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_o <= '0;
      cap_o <= '0;
      tff_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      run_q <= run_n;
      cnt_o <= cnt_n;
      cap_o <= cap_n;
      tff_o <= tff_n;
      irq_o <= irq_n;
    end
  end
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_DIV     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [NUM_DIV-1:0] ce_div_i,
  input  logic               pin_i,
  input  logic               sw_start_i,
  output logic               tff_o,
  output logic               irq_o,
  output logic [CNT_W-1:0]   capture_o
);
  localparam int SEL_W = 2;

  ctrl_t            ctrl_q;
  logic             pin_lvl, pin_rise, pin_fall, src_tick;
  logic [CNT_W-1:0] a_val, b_val, cnt;
  logic             b_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == ADR_CTRL) ctrl_q <= ctrl_t'(reg_wdata_i);
  end

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_o (pin_lvl),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  always_comb begin
    src_tick = 1'b0;
    if (ctrl_q.clk_sel == SEL_PIN) begin
      src_tick = (ctrl_q.start == ST_FALL) ? pin_fall : pin_rise;
    end else begin
      for (int k = 0; k < NUM_DIV; k++)
        if (ctrl_q.clk_sel == SEL_W'(k)) src_tick = ce_div_i[k];
    end
  end

  assign b_ok = (ctrl_q.mode == MODE_PPG);

  tmr_dbuf #(.W(CNT_W)) u_reg_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_lo_i (reg_we_i && reg_addr_i == ADR_A_LO),
    .we_hi_i (reg_we_i && reg_addr_i == ADR_A_HI),
    .wdata_i (reg_wdata_i),
    .load_i  (src_tick),
    .val_o   (a_val)
  );

  tmr_dbuf #(.W(CNT_W)) u_reg_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_lo_i (reg_we_i && b_ok && reg_addr_i == ADR_B_LO),
    .we_hi_i (reg_we_i && b_ok && reg_addr_i == ADR_B_HI),
    .wdata_i (reg_wdata_i),
    .load_i  (src_tick),
    .val_o   (b_val)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl_q),
    .tick_i     (src_tick),
    .lvl_i      (pin_lvl),
    .rise_i     (pin_rise),
    .fall_i     (pin_fall),
    .sw_start_i (sw_start_i),
    .a_i        (a_val),
    .b_i        (b_val),
    .cnt_o      (cnt),
    .cap_o      (capture_o),
    .tff_o      (tff_o),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADR_CTRL:   reg_rdata_o = ctrl_q;
      ADR_A_LO:   reg_rdata_o = a_val[0 +: BYTE_W];
      ADR_A_HI:   reg_rdata_o = a_val[BYTE_W +: BYTE_W];
      ADR_B_LO:   reg_rdata_o = b_val[0 +: BYTE_W];
      ADR_B_HI:   reg_rdata_o = b_val[BYTE_W +: BYTE_W];
      ADR_CAP_LO: reg_rdata_o = capture_o[0 +: BYTE_W];
      ADR_CAP_HI: reg_rdata_o = capture_o[BYTE_W +: BYTE_W];
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/multimode_timer_chk.sv
module multimode_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input ctrl_t            ctrl_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] a_val_i,
  input logic             irq_i,
  input logic             tff_i,
  input logic [CNT_W-1:0] cap_i,
  input logic             rise_i,
  input logic             fall_i
);
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.start == ST_STOP) |=> (cnt_i == '0)); // R4
  AST_TFF_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.start == ST_STOP) |=> (tff_i == $past(ctrl_i.tff_init))); // R4
  AST_STOP_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.start == ST_STOP) |=> !irq_i); // R5
  AST_A_LOADS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(a_val_i) |-> $past(tick_i)); // R2
  AST_PW_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode == MODE_PW && ctrl_i.start != ST_STOP && !rise_i && !fall_i)
      |=> $stable(cap_i)); // R10
  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode == MODE_PPG && ctrl_i.opt && ctrl_i.start != ST_STOP &&
     irq_i && $stable(ctrl_i)) |=> (cnt_i == '0)); // R13
endmodule

bind multimode_timer multimode_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl_i  (ctrl_q),
  .cnt_i   (cnt),
  .tick_i  (src_tick),
  .a_val_i (a_val),
  .irq_i   (irq_o),
  .tff_i   (tff_o),
  .cap_i   (capture_o),
  .rise_i  (pin_rise),
  .fall_i  (pin_fall)
);

// File: tb/multimode_timer_tb_top.sv
`timescale 1ns/100ps
module multimode_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  ce = 3'b001;
  logic        pin = 1'b0;
  logic        sw = 1'b0;
  logic        tff, irq;
  logic [15:0] cap;

  int total = 0, bad = 0, irq_n = 0, tff_n = 0, div_q = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  multimode_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ce_div_i(ce), .pin_i(pin),
    .sw_start_i(sw), .tff_o(tff), .irq_o(irq), .capture_o(cap)
  );

  // ctrl byte: [7] preset, [6] option, [5:4] clock select, [3:2] start, [1:0] mode
  function automatic logic [7:0] cb(logic [1:0] m, logic [1:0] s, logic [1:0] sel,
                                    logic o, logic p);
    return {p, o, sel, s, m};
  endfunction

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      div_q++;
      ce = {div_q % 4 == 0, div_q % 2 == 0, 1'b1};
      if (irq) irq_n++;
      if (tff) tff_n++;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc(1);
    we = 1'b0;
  endtask

  task automatic wr16(logic [2:0] lo, logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 3'd1, v[15:8]);
    cyc(1);
  endtask

  task automatic rd16(logic [2:0] lo, output int v);
    addr = lo;        #0.5; v = rdata;
    addr = lo + 3'd1; #0.5; v = v | (int'(rdata) << 8);
    addr = 3'd0;
  endtask

  task automatic start_cmd();
    sw = 1'b1; cyc(1); sw = 1'b0;
  endtask

  task automatic pulse(int hi, int lo);
    pin = 1'b1; cyc(hi); pin = 1'b0; cyc(lo);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 tff", tff, 0);
    chk("R1 irq", irq, 0);
    chk("R1 capture", cap, 0);
    rd16(3'd1, v); chk("R1 A", v, 16'hFFFF);
    rd16(3'd3, v); chk("R1 B", v, 16'hFFFF);
  endtask

  task automatic t_autocap();
    wr(3'd0, cb(2'b00, 2'b01, 2'b00, 1'b1, 1'b0));
    start_cmd();
    cyc(9);
    chk("R6 live capture", cap, 9);
    wr(3'd0, cb(2'b00, 2'b00, 2'b00, 1'b1, 1'b0));
    wr(3'd0, cb(2'b00, 2'b01, 2'b00, 1'b1, 1'b0));
    cyc(2);
    chk("R4 stop clears count", cap, 0);
    wr(3'd0, cb(2'b00, 2'b00, 2'b00, 1'b0, 1'b1));
    cyc(1);
    chk("R4 preset 1", tff, 1);
    wr(3'd0, cb(2'b00, 2'b00, 2'b00, 1'b0, 1'b0));
    cyc(1);
    chk("R4 preset 0", tff, 0);
  endtask

  task automatic t_dbuf();
    int v;
    wr(3'd1, 8'h34);
    cyc(5);
    rd16(3'd1, v); chk("R2 low only", v, 16'hFFFF);
    wr(3'd2, 8'h12);
    rd16(3'd1, v); chk("R2 pending before tick", v, 16'hFFFF);
    cyc(1);
    rd16(3'd1, v); chk("R2 loaded after tick", v, 16'h1234);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    cyc(3);
    rd16(3'd3, v); chk("R3 B locked", v, 16'hFFFF);
  endtask

  task automatic t_timer();
    wr16(3'd1, 16'd5);
    wr(3'd0, cb(2'b00, 2'b01, 2'b00, 1'b0, 1'b0));
    irq_n = 0; cyc(10);
    chk("R5 idle before command", irq_n, 0);
    start_cmd(); cyc(3);
    irq_n = 0; cyc(25);
    chk("R5 period A", irq_n, 5);
  endtask

  task automatic t_clksel();
    wr(3'd0, 8'h00);
    wr(3'd0, cb(2'b00, 2'b01, 2'b01, 1'b0, 1'b0));
    start_cmd(); cyc(12);
    irq_n = 0; cyc(40);
    chk("R14 select div1", irq_n, 4);
    wr(3'd0, 8'h00);
    wr(3'd0, cb(2'b00, 2'b01, 2'b10, 1'b0, 1'b0));
    start_cmd(); cyc(24);
    irq_n = 0; cyc(40);
    chk("R14 select div2", irq_n, 2);
  endtask

  task automatic t_trig();
    wr(3'd0, 8'h00);
    wr16(3'd1, 16'd4);
    wr(3'd0, cb(2'b00, 2'b10, 2'b00, 1'b0, 1'b0));
    irq_n = 0; cyc(12);
    chk("R7 waits for edge", irq_n, 0);
    pulse(2, 4);
    irq_n = 0; cyc(20);
    chk("R7 started", irq_n, 5);
    pulse(2, 4);
    irq_n = 0; cyc(20);
    chk("R7 option 0 ignores edge", irq_n, 5);
    wr(3'd0, 8'h00);
    wr(3'd0, cb(2'b00, 2'b10, 2'b00, 1'b1, 1'b0));
    pulse(2, 4);
    irq_n = 0; cyc(20);
    chk("R7 start-stop started", irq_n, 5);
    pulse(2, 4);
    irq_n = 0; cyc(20);
    chk("R7 second edge stops", irq_n, 0);
  endtask

  task automatic t_event();
    wr(3'd0, 8'h00);
    wr16(3'd1, 16'd3);
    wr(3'd0, cb(2'b00, 2'b10, 2'b11, 1'b0, 1'b0));
    irq_n = 0;
    pulse(3, 3); pulse(3, 3); cyc(5);
    chk("R8 two edges", irq_n, 0);
    pulse(3, 3); cyc(5);
    chk("R8 third edge matches", irq_n, 1);
  endtask

  task automatic t_window();
    wr(3'd0, 8'h00);
    wr16(3'd1, 16'd10);
    wr(3'd0, cb(2'b01, 2'b10, 2'b00, 1'b0, 1'b0));
    irq_n = 0;
    pulse(6, 20);
    chk("R9 gated low", irq_n, 0);
    pulse(4, 6);
    chk("R9 ten high ticks", irq_n, 1);
  endtask

  task automatic t_pw_single();
    wr(3'd0, 8'h00);
    wr(3'd0, cb(2'b10, 2'b10, 2'b00, 1'b1, 1'b0));
    irq_n = 0;
    pulse(7, 3);
    chk("R10 width 7", cap, 7);
    cyc(3);
    pulse(4, 3);
    chk("R10 width 4", cap, 4);
    chk("R10 irq per capture", irq_n, 2);
  endtask

  task automatic t_pw_double();
    wr(3'd0, 8'h00);
    wr(3'd0, cb(2'b10, 2'b10, 2'b00, 1'b0, 1'b0));
    irq_n = 0;
    pulse(5, 3);
    chk("R11 high width", cap, 5);
    pin = 1'b1; cyc(3);
    chk("R11 period", cap, 8);
    pin = 1'b0; cyc(3);
    chk("R11 restarted width", cap, 3);
    chk("R11 irq count", irq_n, 3);
  endtask

  task automatic t_ppg();
    int v;
    wr(3'd0, cb(2'b11, 2'b00, 2'b00, 1'b0, 1'b0));
    wr16(3'd1, 16'd8);
    wr16(3'd3, 16'd3);
    rd16(3'd3, v); chk("R3 B writable in pulse mode", v, 3);
    wr(3'd0, cb(2'b11, 2'b01, 2'b00, 1'b0, 1'b0));
    start_cmd();
    tff_n = 0; irq_n = 0; cyc(16);
    chk("R12 high cycles", tff_n, 10);
    chk("R12 irq", irq_n, 2);
    wr(3'd0, cb(2'b11, 2'b00, 2'b00, 1'b0, 1'b0));
    wr(3'd0, cb(2'b11, 2'b01, 2'b00, 1'b1, 1'b0));
    start_cmd();
    tff_n = 0; irq_n = 0; cyc(40);
    chk("R13 single pulse", tff_n, 5);
    chk("R13 single irq", irq_n, 1);
    chk("R13 output held", tff, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_autocap();
    t_dbuf();
    t_timer();
    t_clksel();
    t_trig();
    t_event();
    t_window();
    t_pw_single();
    t_pw_double();
    t_ppg();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule